// File: doc/BRIEF.md
# Pipelined Accumulator Processor Core

This block is a compact processor core with separate program and data buses. Each cycle it reads a 14-bit instruction word from the program port while it executes the word fetched in the previous cycle. Straight-line code therefore retires one instruction per clock. All arithmetic goes through an 8-bit working accumulator (W) and one operand taken from a 128-entry data register file reached through the data port. A single destination bit in each byte-oriented instruction decides whether the result lands in W or goes back to the addressed register.

Control transfers (a taken bit-test skip, a jump, a return, or entry to the interrupt handler) throw away the word already prefetched and replace it with a no-op. Each of them therefore costs one extra cycle. An interrupt request pushes the address of the discarded word onto a small return stack and redirects fetch to the handler entry. A return instruction pops that address and enables interrupts again. Both memories sit outside the block and must answer reads combinationally, within the same cycle.

Top module: `ovl_core`

## Requirements
- R1: While rst_n is low at a clock edge, the core clears W, the zero and carry flags and the return stack, enables interrupts and sets the fetch address to 0x000. The first word fetched after reset therefore comes from 0x000.
- R2: While no control transfer happens, the fetch address rises by one every cycle. A word fetched in cycle t executes in cycle t+1, and its W result is visible after the edge that ends cycle t+1.
- R3: Byte-oriented words take the opcode from bits 13:8, the destination from bit 7 (0 = W, 1 = file register) and the register address from bits 6:0. The opcodes are 0x07 for add W+f, 0x04 for OR W|f, 0x08 for move f and 0x01 for clear. A file destination writes the result through the data port in the executing cycle.
- R4: All four byte-oriented operations set the zero flag to (result == 0). Only add updates the carry flag, which takes the carry out of the 8-bit sum.
- R5: Opcode 0x30 in bits 13:8 loads bits 7:0 into W and leaves both flags unchanged.
- R6: Bits 13:10 equal to 0110 test and skip if the bit is clear. Bits 13:10 equal to 0111 test and skip if the bit is set. Bits 9:7 select the bit and bits 6:0 select the register. A taken skip turns the prefetched word into a no-op, so the test takes two cycles and the skipped word never executes.
- R7: Bits 13:11 equal to 101 form a jump to bits 10:0, zero-extended to 13 bits. The prefetched word is discarded and the target is fetched in the next cycle.
- R8: When irq is high, interrupts are enabled, and the executing word is neither a jump, a return nor a taken skip, the executing word still completes. The prefetched word is discarded and its address is pushed. The next fetch comes from 0x004 and interrupts are disabled, so irq held high inside the handler is not taken.
- R9: Word 0x0008 returns. It pops the pushed address, fetch resumes there in the next cycle, and interrupts are enabled again.
- R10: Word 0x0000 and every encoding not listed above change neither W, the flags nor any file register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Level-sensitive interrupt request |
| imem_addr | output | 13 | Program memory word address |
| imem_data | input | 14 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 7 | Data register file address |
| dmem_rdata | input | 8 | Register contents at dmem_addr, same cycle |
| dmem_we | output | 1 | Write strobe, taken at the clock edge |
| dmem_wdata | output | 8 | Data written when dmem_we is high |
| w_out | output | 8 | Current W accumulator |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |

## Verification
The properties assume that both memories return data for the presented address within the same cycle, with no unknown bits. They also assume that irq stays steady between clock edges. The bench models both memories as combinational arrays in the bench and changes irq only at falling edges. Random programs use only listed and explicitly unused encodings, and they end in a jump to themselves, so execution never runs off the written code. The interrupt is exercised only in a directed program whose handler does not touch W, so that a jump, return or taken skip never meets an unexpected request.

// File: rtl/ovl_pkg.sv
// Shared widths, vectors and decoded-control types for the accumulator core.
// Assumes 14-bit instruction words and an 8-bit data path.
package ovl_pkg;
    localparam int PC_W   = 13;
    localparam int IW     = 14;
    localparam int DW     = 8;
    localparam int FA_W   = 7;
    localparam int BIT_W  = $clog2(DW);
    localparam int GOTO_W = 11;

    localparam logic [PC_W-1:0] RESET_VEC = 13'h000;
    localparam logic [PC_W-1:0] IRQ_VEC   = 13'h004;
    localparam logic [IW-1:0]   NOP_WORD  = 14'h0000;
    localparam logic [IW-1:0]   RET_WORD  = 14'h0008;

    typedef enum logic [3:0] {
        OP_NOP, OP_ADD, OP_IOR, OP_MOV, OP_CLR,
        OP_LIT, OP_BTS, OP_GOTO, OP_RET
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              to_file;
        logic [FA_W-1:0]   faddr;
        logic [BIT_W-1:0]  bitsel;
        logic              skip_if_set;
        logic [GOTO_W-1:0] target;
    } ctrl_t;
endpackage

// File: rtl/ovl_decode.sv
// Instruction decoder: turns the executing word into control fields.
// Assumes the word is stable for the whole cycle; purely combinational.
module ovl_decode
    import ovl_pkg::*;
(
    input  logic [IW-1:0] ir,
    output ctrl_t         ctl
);
    // Field extraction and opcode classification.
    always_comb begin
        ctl.to_file     = ir[7];
        ctl.faddr       = ir[FA_W-1:0];
        ctl.bitsel      = ir[9:7];
        ctl.skip_if_set = ir[10];
        ctl.target      = ir[GOTO_W-1:0];
        ctl.op          = OP_NOP;
        if (ir == RET_WORD) begin
            ctl.op = OP_RET;
        end else begin
            casez (ir[13:8])
                6'b000111: ctl.op = OP_ADD;
                6'b000100: ctl.op = OP_IOR;
                6'b001000: ctl.op = OP_MOV;
                6'b000001: ctl.op = OP_CLR;
                6'b110000: ctl.op = OP_LIT;
                6'b011???: ctl.op = OP_BTS;
                6'b101???: ctl.op = OP_GOTO;
                default:   ctl.op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ovl_alu.sv
// Byte ALU: combines W with the file operand for the byte-oriented group.
// Assumes the caller decides which flags to keep; zero is always computed.
module ovl_alu
    import ovl_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    output logic [DW-1:0] res,
    output logic          zero,
    output logic          carry
);
    // Result and flag generation.
    always_comb begin
        carry = 1'b0;
        res   = f;
        case (op)
            OP_ADD:  {carry, res} = {1'b0, w} + {1'b0, f};
            OP_IOR:  res = w | f;
            OP_CLR:  res = '0;
            default: res = f;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/ovl_stack.sv
// Return-address stack: a small circular LIFO of program addresses.
// Assumes push and pop are never requested in the same cycle.
module ovl_stack #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] top_idx;

    assign top_idx = ptr_q - PTR_W'(1);
    assign dout    = slots[top_idx];

    // Stack pointer movement.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (push) ptr_q <= ptr_q + PTR_W'(1);
        else if (pop)  ptr_q <= top_idx;
    end

    // Slot storage on push.
    always_ff @(posedge clk) begin
        if (push) slots[ptr_q] <= din;
    end
endmodule

// File: rtl/ovl_core.sv
// Two-stage accumulator core: fetch of word N+1 overlaps execution of word N.
// Assumes program and data memories answer reads combinationally.
module ovl_core
    import ovl_pkg::*;
#(
    parameter int STACK_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    output logic [PC_W-1:0] imem_addr,
    input  logic [IW-1:0]   imem_data,
    output logic [FA_W-1:0] dmem_addr,
    input  logic [DW-1:0]   dmem_rdata,
    output logic            dmem_we,
    output logic [DW-1:0]   dmem_wdata,
    output logic [DW-1:0]   w_out,
    output logic            z_out,
    output logic            c_out
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] stk_top;
    logic [IW-1:0]   ir_q;
    logic [DW-1:0]   w_q;
    logic            z_q, c_q, gie_q;
    ctrl_t           ctl;
    logic [DW-1:0]   alu_res;
    logic            alu_z, alu_c;
    logic            is_alu, skip_taken, redirect, irq_take;
    logic            is_goto, is_ret;

    ovl_decode u_dec (.ir(ir_q), .ctl(ctl));

    ovl_alu u_alu (
        .op(ctl.op), .w(w_q), .f(dmem_rdata),
        .res(alu_res), .zero(alu_z), .carry(alu_c)
    );

    ovl_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PC_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(irq_take), .pop(is_ret),
        .din(pc_q), .dout(stk_top)
    );

    // Execute-stage control: skip test, redirects and interrupt acceptance.
    always_comb begin
        is_alu     = ctl.op inside {OP_ADD, OP_IOR, OP_MOV, OP_CLR};
        is_goto    = (ctl.op == OP_GOTO);
        is_ret     = (ctl.op == OP_RET);
        skip_taken = (ctl.op == OP_BTS) &&
                     (dmem_rdata[ctl.bitsel] == ctl.skip_if_set);
        redirect   = skip_taken || is_goto || is_ret;
        irq_take   = irq && gie_q && !redirect;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = ctl.faddr;
    assign dmem_we    = is_alu && ctl.to_file;
    assign dmem_wdata = alu_res;
    assign w_out      = w_q;
    assign z_out      = z_q;
    assign c_out      = c_q;

    // Fetch stage: next program address and the word handed to execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
            ir_q <= NOP_WORD;
        end else if (irq_take) begin
            pc_q <= IRQ_VEC;
            ir_q <= NOP_WORD;
        end else if (is_goto) begin
            pc_q <= {{(PC_W-GOTO_W){1'b0}}, ctl.target};
            ir_q <= NOP_WORD;
        end else if (is_ret) begin
            pc_q <= stk_top;
            ir_q <= NOP_WORD;
        end else begin
            pc_q <= pc_q + PC_W'(1);
            ir_q <= skip_taken ? NOP_WORD : imem_data;
        end
    end

    // Execute stage: accumulator and status flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            if (is_alu) begin
                z_q <= alu_z;
                if (!ctl.to_file) w_q <= alu_res;
            end
            if (ctl.op == OP_ADD) c_q <= alu_c;
            if (ctl.op == OP_LIT) w_q <= ir_q[DW-1:0];
        end
    end

    // Global interrupt enable: cleared on entry, restored on return.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b1;
        else if (irq_take) gie_q <= 1'b0;
        else if (is_ret)   gie_q <= 1'b1;
    end
endmodule

// File: rtl/ovl_core_chk.sv
// Property checker for the accumulator core, attached through bind.
// Assumes a synchronous active-low reset and combinational memories.
module ovl_core_chk
    import ovl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic [PC_W-1:0] imem_addr,
    input logic            dmem_we,
    input logic [DW-1:0]   w_out,
    input logic            z_out,
    input logic            c_out,
    input logic [IW-1:0]   ir,
    input ctrl_t           ctl,
    input logic            skip_taken,
    input logic            irq_take
);
    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_VEC && w_out == '0 && !z_out && !c_out));

    assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (ctl.op inside {OP_NOP, OP_ADD, OP_IOR, OP_MOV, OP_CLR, OP_LIT}))
        |=> imem_addr == $past(imem_addr) + PC_W'(1));

    assert_literal_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.op == OP_LIT) |=> (w_out == $past(ir[DW-1:0]) && $stable(z_out) && $stable(c_out)));

    assert_bubble_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_taken || ctl.op == OP_GOTO) |=> !dmem_we);

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.op == OP_GOTO) |=> imem_addr == {2'b00, $past(ir[10:0])});

    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> imem_addr == IRQ_VEC);
endmodule

bind ovl_core ovl_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .imem_addr(imem_addr),
    .dmem_we(dmem_we), .w_out(w_out), .z_out(z_out), .c_out(c_out),
    .ir(ir_q), .ctl(ctl), .skip_taken(skip_taken), .irq_take(irq_take)
);

// File: tb/ovl_core_tb_top.sv
`timescale 1ns/1ps
module ovl_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [12:0] imem_addr;
    logic [13:0] imem_data;
    logic [6:0]  dmem_addr;
    logic [7:0]  dmem_rdata;
    logic        dmem_we;
    logic [7:0]  dmem_wdata;
    logic [7:0]  w_out;
    logic        z_out, c_out;

    logic [13:0] prog [0:255];
    logic [7:0]  dmem [0:127];
    logic [7:0]  mmem [0:127];
    logic        ld_en = 1'b0;
    logic [6:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [7:0]  mw;
    logic        mz, mc;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ovl_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .w_out(w_out), .z_out(z_out), .c_out(c_out)
    );

    assign imem_data  = prog[imem_addr[7:0]];
    assign dmem_rdata = dmem[dmem_addr];

    // Data memory: bench loader while idle, core writes otherwise.
    always @(posedge clk) begin
        if (ld_en) dmem[ld_addr] <= ld_data;
        else if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] w_file(input logic [5:0] op, input logic d, input logic [6:0] a);
        return {op, d, a};
    endfunction
    function automatic logic [13:0] w_btst(input logic set, input logic [2:0] b, input logic [6:0] a);
        return {3'b011, set, b, a};
    endfunction
    function automatic logic [13:0] w_lit(input logic [7:0] k);
        return {6'h30, k};
    endfunction
    function automatic logic [13:0] w_goto(input logic [10:0] t);
        return {3'b101, t};
    endfunction

    // Sequential reference interpreter built from the requirements.
    task automatic model_run(input int stop_pc);
        int pc = 0;
        int guard = 0;
        while (pc != stop_pc && guard < 1000) begin
            logic [13:0] ins = prog[pc];
            logic [7:0]  fv = mmem[ins[6:0]];
            logic [8:0]  sum;
            logic [7:0]  res;
            bit          alu = 1'b0;
            guard++;
            if (ins[13:11] == 3'b101) begin
                pc = int'(ins[10:0]);
            end else if (ins[13:11] == 3'b011) begin
                pc = (fv[ins[9:7]] == ins[10]) ? pc + 2 : pc + 1;
            end else begin
                case (ins[13:8])
                    6'h07: begin sum = {1'b0, mw} + {1'b0, fv}; res = sum[7:0]; mc = sum[8]; alu = 1'b1; end
                    6'h04: begin res = mw | fv; alu = 1'b1; end
                    6'h08: begin res = fv; alu = 1'b1; end
                    6'h01: begin res = 8'h00; alu = 1'b1; end
                    6'h30: mw = ins[7:0];
                    default: ;
                endcase
                if (alu) begin
                    mz = (res == 8'h00);
                    if (ins[7]) mmem[ins[6:0]] = res;
                    else mw = res;
                end
                pc = pc + 1;
            end
        end
    endtask

    task automatic enter_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(imem_addr == 13'h0 && w_out == 8'h0 && !z_out && !c_out, "R1 reset state",
            {w_out, 2'b0, z_out, c_out, imem_addr}, 32'h0);
    endtask

    task automatic load_mem();
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 7'(i); ld_data = mmem[i];
        end
        @(negedge clk) ld_en = 1'b0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 14'h0000;
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_prog();
        for (int i = 0; i < 128; i++) mmem[i] = 8'h00;

        // ---- Directed: throughput and literal load (R1, R2, R5)
        enter_reset();
        for (int i = 0; i < 24; i++) prog[i] = w_lit(8'h40 + 8'(i));
        load_mem();
        @(negedge clk) rst_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            chk(imem_addr == 13'(k), "R2 fetch step", imem_addr, k);
            if (k >= 2) chk(w_out == 8'h40 + 8'(k - 2), "R5 literal to W", w_out, 8'h40 + 8'(k - 2));
        end

        // ---- Directed: skips and jump (R6, R7)
        enter_reset();
        clear_prog();
        mmem[5] = 8'h80;
        prog[0] = w_btst(1'b1, 3'd7, 7'd5);
        prog[1] = w_lit(8'hAA);
        prog[2] = w_btst(1'b0, 3'd7, 7'd5);
        prog[3] = w_lit(8'h55);
        prog[4] = w_btst(1'b0, 3'd0, 7'd5);
        prog[5] = w_lit(8'h99);
        prog[6] = w_goto(11'd9);
        prog[7] = w_lit(8'h11);
        prog[8] = w_lit(8'h22);
        prog[9] = w_goto(11'd9);
        load_mem();
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk(imem_addr == 13'd3, "R6 taken skip costs two cycles", imem_addr, 3);
        repeat (2) @(posedge clk); #1;
        chk(w_out == 8'h55, "R6 untaken skip executes next word", w_out, 8'h55);
        repeat (3) @(posedge clk); #1;
        chk(imem_addr == 13'd9, "R7 jump target fetched", imem_addr, 9);
        repeat (10) @(posedge clk); #1;
        chk(w_out == 8'h55, "R7 dropped words never execute", w_out, 8'h55);

        // ---- Directed: interrupt entry, masking and return (R8, R9)
        enter_reset();
        clear_prog();
        prog[0] = w_goto(11'd8);
        prog[4] = w_file(6'h01, 1'b1, 7'h10);
        prog[5] = w_file(6'h07, 1'b1, 7'h10);
        prog[6] = 14'h0008;
        for (int i = 8; i <= 30; i++) prog[i] = w_lit(8'(i));
        prog[31] = w_goto(11'd31);
        for (int i = 0; i < 128; i++) mmem[i] = 8'h00;
        load_mem();
        @(negedge clk) rst_n = 1'b1;
        while (imem_addr != 13'd14) @(negedge clk);
        irq = 1'b1;
        @(posedge clk); #1;
        chk(imem_addr == 13'h004, "R8 vector fetch", imem_addr, 4);
        @(posedge clk); #1;
        chk(imem_addr == 13'h005, "R8 request masked in handler", imem_addr, 5);
        @(negedge clk) irq = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(imem_addr == 13'd14, "R9 return resumes at dropped word", imem_addr, 14);
        @(negedge clk) irq = 1'b1;
        @(posedge clk); #1;
        chk(imem_addr == 13'h004, "R9 interrupts enabled again", imem_addr, 4);
        @(negedge clk) irq = 1'b0;
        repeat (40) @(posedge clk); #1;
        chk(dmem[7'h10] == 8'd13, "R8 executing word completes", dmem[7'h10], 13);
        chk(w_out == 8'd30, "R9 main program finishes", w_out, 30);

        // ---- Random programs against the reference interpreter (R3, R4, R6, R10)
        for (int round = 0; round < 6; round++) begin
            int mism = 0;
            enter_reset();
            clear_prog();
            for (int i = 0; i < 39; i++) begin
                logic [6:0] a = 7'($urandom_range(0, 15));
                logic       d = 1'($urandom);
                case ($urandom_range(0, 8))
                    0: prog[i] = w_file(6'h07, d, a);
                    1: prog[i] = w_file(6'h04, d, a);
                    2: prog[i] = w_file(6'h08, d, a);
                    3: prog[i] = w_file(6'h01, d, a);
                    4: prog[i] = w_lit(8'($urandom));
                    5: prog[i] = w_btst(1'b0, 3'($urandom), a);
                    6: prog[i] = w_btst(1'b1, 3'($urandom), a);
                    7: prog[i] = 14'h0000;
                    default: prog[i] = {6'h3E, d, a};
                endcase
            end
            prog[39] = w_lit(8'($urandom));
            prog[40] = w_goto(11'd40);
            for (int i = 0; i < 128; i++) mmem[i] = (i < 16) ? 8'($urandom) : 8'h00;
            if (round == 0) mmem[3] = 8'hFF;
            load_mem();
            mw = 8'h00; mz = 1'b0; mc = 1'b0;
            model_run(40);
            @(negedge clk) rst_n = 1'b1;
            repeat (120) @(posedge clk);
            @(negedge clk);
            chk(w_out == mw, "R3 random W result", w_out, mw);
            chk(z_out == mz, "R4 random zero flag", z_out, mz);
            chk(c_out == mc, "R4 random carry flag", c_out, mc);
            for (int i = 0; i < 128; i++) if (dmem[i] !== mmem[i]) mism++;
            chk(mism == 0, "R10 random register file", mism, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule